// File: doc/BRIEF.md
# Programmable Field Sequence Selector

This block steps through a short, programmable list of stored field-profile selections, one entry per video field. Every falling edge of the vertical sync input (VD) moves it to the next entry of the list. After the last entry it returns to the first. Its output tells the downstream vertical timing generators which stored profile to use in the current field, and which step of the list is active. All field profiles are loaded once. After that, a camera changes its operating mode with only a few register writes.

Software programs three registers through a simple write port: a length register and two packed selection registers. The low selection register holds the indices for steps one to five. The high selection register holds the indices for steps six and seven. Only a write to the high selection register restarts the list at step one, so the three registers are normally written together within one field. An optional deferred mode keeps the written values in shadow storage. The shadow values become active on the second VD falling edge after the most recent write.

Top module: `field_seq_selector`

## Requirements
- R1: After reset, `step_num` is 0 (step one), `field_idx` is 0, the list length is 1 and all stored indices are 0.
- R2: VD is synchronised by two flops. Each VD falling edge advances the step exactly once, and the new step appears three clock edges after VD falls. A VD rising edge leaves the step unchanged.
- R3: The length register is written at address 0, data bits [2:0]. When it is advanced from step number `len-1`, the step returns to 0. A length of 0 behaves as a length of 1, so the step stays at 0.
- R4: `field_idx` equals the stored index of the active step. The low selection register is at address 1 and holds step k (k = 0..4) in data bits [5k+4:5k]. The high selection register is at address 2 and holds step 5 in bits [4:0] and step 6 in bits [9:5].
- R5: A write to address 2 returns the step to 0. Writes to address 0 or address 1 do not change the step.
- R6: When `upd_on_vd` is 0, a write takes effect on the clock edge that captures it.
- R7: When `upd_on_vd` is 1, a write does not change the active settings. The shadow copies become active on the second VD falling edge after the latest write, and any further write starts this count again. The first falling edge still advances the step using the old settings.
- R8: In deferred mode, a write to address 2 returns the step to 0 on the edge where the settings become active, and not at the time of the write.
- R9: A write to any other address (3 to 15) has no effect on the outputs or on the sequence that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address: 0 length, 1 low selection, 2 high selection |
| wr_data | input | 32 | Write data |
| upd_on_vd | input | 1 | 1 selects deferred (VD-latched) updates |
| vd | input | 1 | Vertical sync, asynchronous to clk |
| field_idx | output | 5 | Stored profile index of the active step |
| step_num | output | 3 | Active step, 0 meaning step one |

## Verification
If the step counter is wrong, `field_idx` shows the index of a different slot. This is visible three clock edges after the VD fall that should have produced the correct step. Each step is given a distinct index, so an error in the wrap point or in the length handling appears at the first wrong field. If the deferred state is wrong, new settings appear one field too early or one field too late, which `field_idx` shows at the affected edge. If the restart is lost, `step_num` shows it in the field after the high register becomes active.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   // Register addresses; the address decode depends on these values.
   localparam int unsigned FSEQ_ADDR_LEN    = 0;
   localparam int unsigned FSEQ_ADDR_SEL_LO = 1;
   localparam int unsigned FSEQ_ADDR_SEL_HI = 2;

   // A programmed length of 0 is treated as 1; a length above the slot count is clamped.
   function automatic int unsigned fseq_eff_len(int unsigned len, int unsigned slots);
      if (len == 0)
         return 1;
      if (len > slots)
         return slots;
      return len;
   endfunction

endpackage

// File: rtl/fseq_vd_fall.sv
module fseq_vd_fall #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vd_async,
   output logic vd_fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fseq_vd_fall: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              lvl;

   assign lvl = sync_q[STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], vd_async};
         prev_q <= lvl;
      end
   end

   assign vd_fall = prev_q & ~lvl;

   // R2: one VD fall produces a single one-cycle advance pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vd_fall |=> !vd_fall);

endmodule

// File: rtl/fseq_cfg.sv
module fseq_cfg
   import fseq_pkg::*;
#(
   parameter int unsigned SLOTS       = 7,
   parameter int unsigned SLOTS_LO    = 5,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned LEN_W       = 3,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned APPLY_EDGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    upd_on_vd,
   input  logic                    vd_fall,
   output logic [LEN_W-1:0]        act_len,
   output logic [SLOTS*IDX_W-1:0]  act_flat,
   output logic                    restart
);

   localparam int unsigned SLOTS_HI = SLOTS - SLOTS_LO;
   localparam int unsigned EW       = $clog2(APPLY_EDGES);

   if (SLOTS_LO < 1 || SLOTS_HI < 1) begin : g_bad_split
      $error("fseq_cfg: both selection registers need at least one slot");
   end
   if (SLOTS_LO * IDX_W > DATA_W || SLOTS_HI * IDX_W > DATA_W) begin : g_bad_data
      $error("fseq_cfg: DATA_W too narrow for packed slots");
   end
   if (LEN_W > DATA_W) begin : g_bad_len
      $error("fseq_cfg: LEN_W wider than DATA_W");
   end
   if (APPLY_EDGES < 2) begin : g_bad_edges
      $error("fseq_cfg: APPLY_EDGES must be at least 2");
   end

   logic hit_len, hit_lo, hit_hi, hit_any, defer_wr, apply;
   logic unused_data;

   assign hit_len  = wr_en && (wr_addr == ADDR_W'(FSEQ_ADDR_LEN));
   assign hit_lo   = wr_en && (wr_addr == ADDR_W'(FSEQ_ADDR_SEL_LO));
   assign hit_hi   = wr_en && (wr_addr == ADDR_W'(FSEQ_ADDR_SEL_HI));
   assign hit_any  = hit_len || hit_lo || hit_hi;
   assign defer_wr = upd_on_vd && hit_any;
   assign unused_data = ^wr_data;

   // Deferred-update tracking
   logic          pend_q;
   logic          hi_pend_q;
   logic [EW-1:0] edge_q;

   assign apply   = pend_q && vd_fall && !defer_wr && (edge_q == EW'(APPLY_EDGES - 1));
   assign restart = (hit_hi && !upd_on_vd) || (apply && hi_pend_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         hi_pend_q <= 1'b0;
         edge_q    <= '0;
      end else if (defer_wr) begin
         pend_q    <= 1'b1;
         hi_pend_q <= hi_pend_q || hit_hi;
         edge_q    <= '0;
      end else if (apply) begin
         pend_q    <= 1'b0;
         hi_pend_q <= 1'b0;
         edge_q    <= '0;
      end else if (pend_q && vd_fall) begin
         edge_q    <= edge_q + EW'(1);
      end
   end

   // Length register: shadow always tracks writes, active follows mode
   logic [LEN_W-1:0] shd_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_len <= LEN_W'(1);
         act_len <= LEN_W'(1);
      end else begin
         if (hit_len)
            shd_len <= wr_data[LEN_W-1:0];
         if (hit_len && !upd_on_vd)
            act_len <= wr_data[LEN_W-1:0];
         else if (apply)
            act_len <= shd_len;
      end
   end

   // Slot registers, one generate branch per slot
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam bit          IN_LO = (s < SLOTS_LO);
      localparam int unsigned OFF   = IN_LO ? s * IDX_W : (s - SLOTS_LO) * IDX_W;

      logic             hit;
      logic [IDX_W-1:0] shd_q;
      logic [IDX_W-1:0] act_q;

      if (IN_LO) begin : g_lo
         assign hit = hit_lo;
      end else begin : g_hi
         assign hit = hit_hi;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (hit)
               shd_q <= wr_data[OFF +: IDX_W];
            if (hit && !upd_on_vd)
               act_q <= wr_data[OFF +: IDX_W];
            else if (apply)
               act_q <= shd_q;
         end
      end

      assign act_flat[s*IDX_W +: IDX_W] = act_q;
   end

   // R7: in deferred mode the active length moves only on an apply edge
   a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!(hit_len && !upd_on_vd) && !apply) |=> $stable(act_len));

   // R7: a pending update survives cycles without a VD fall
   a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !vd_fall) |=> pend_q);

   // R8: a deferred write never restarts the sequence at write time
   a_r8_no_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_on_vd && hit_hi && !pend_q) |-> !restart);

endmodule

// File: rtl/fseq_stepper.sv
module fseq_stepper
   import fseq_pkg::*;
#(
   parameter int unsigned SLOTS = 7,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned LEN_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   advance,
   input  logic                   restart,
   input  logic [LEN_W-1:0]       len,
   input  logic [SLOTS*IDX_W-1:0] slot_flat,
   output logic [IDX_W-1:0]       field_idx,
   output logic [LEN_W-1:0]       step_num
);

   if (SLOTS >= (1 << LEN_W)) begin : g_bad_width
      $error("fseq_stepper: LEN_W too narrow for SLOTS");
   end

   logic [IDX_W-1:0] slot_arr [SLOTS];
   logic [LEN_W-1:0] step_q;
   logic [LEN_W-1:0] eff_len;
   logic [LEN_W:0]   step_inc;

   for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
      assign slot_arr[s] = slot_flat[s*IDX_W +: IDX_W];
   end

   assign eff_len  = LEN_W'(fseq_eff_len(int'(len), SLOTS));
   assign step_inc = {1'b0, step_q} + (LEN_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         step_q <= '0;
      else if (restart)
         step_q <= '0;
      else if (advance)
         step_q <= (step_inc >= {1'b0, eff_len}) ? '0 : step_inc[LEN_W-1:0];
   end

   assign field_idx = slot_arr[step_q];
   assign step_num  = step_q;

   // R2: without an advance or restart the step holds
   a_r2_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(step_q));

   // R3: the step always names an existing slot
   a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_q < LEN_W'(SLOTS));

   // R3: length 0 or 1 keeps the sequence on step one
   a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && len <= LEN_W'(1) && step_q == '0) |=> (step_q == '0));

   // R5: a restart lands on step one
   a_r5_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (step_q == '0));

endmodule

// File: rtl/field_seq_selector.sv
module field_seq_selector
   import fseq_pkg::*;
#(
   parameter int unsigned SLOTS       = 7,
   parameter int unsigned SLOTS_LO    = 5,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned APPLY_EDGES = 2,
   localparam int unsigned LEN_W      = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              upd_on_vd,
   input  logic              vd,
   output logic [IDX_W-1:0]  field_idx,
   output logic [LEN_W-1:0]  step_num
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("field_seq_selector: ADDR_W must cover three registers");
   end

   logic                   vd_fall;
   logic [LEN_W-1:0]       act_len;
   logic [SLOTS*IDX_W-1:0] act_flat;
   logic                   restart;

   fseq_vd_fall #(
      .STAGES (SYNC_STAGES)
   ) u_vd (
      .clk      (clk),
      .rst_n    (rst_n),
      .vd_async (vd),
      .vd_fall  (vd_fall)
   );

   fseq_cfg #(
      .SLOTS       (SLOTS),
      .SLOTS_LO    (SLOTS_LO),
      .IDX_W       (IDX_W),
      .LEN_W       (LEN_W),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .APPLY_EDGES (APPLY_EDGES)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .upd_on_vd (upd_on_vd),
      .vd_fall   (vd_fall),
      .act_len   (act_len),
      .act_flat  (act_flat),
      .restart   (restart)
   );

   fseq_stepper #(
      .SLOTS (SLOTS),
      .IDX_W (IDX_W),
      .LEN_W (LEN_W)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (vd_fall),
      .restart   (restart),
      .len       (act_len),
      .slot_flat (act_flat),
      .field_idx (field_idx),
      .step_num  (step_num)
   );

   // R1: the first cycle after reset shows step one
   a_r1_reset_step: assert property (@(posedge clk)
      !rst_n |=> (step_num == '0));

endmodule

// File: tb/field_seq_selector_test.sv
module field_seq_selector_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        upd_on_vd = 1'b0;
   logic        vd = 1'b0;
   logic [4:0]  field_idx;
   logic [2:0]  step_num;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_slot [7];
   int n_slot [7];
   int m_len = 1;
   int m_step = 0;

   always #5 clk = ~clk;

   field_seq_selector uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .upd_on_vd(upd_on_vd), .vd(vd),
      .field_idx(field_idx), .step_num(step_num)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic chk_out(string req);
      chk({req, " step"}, int'(step_num), m_step);
      chk({req, " index"}, int'(field_idx), m_slot[m_step]);
   endtask

   task automatic wr(int addr, logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [31:0] pack_lo(int s[7]);
      logic [31:0] d = '0;
      for (int k = 0; k < 5; k++) d[k*5 +: 5] = 5'(s[k]);
      return d;
   endfunction

   function automatic logic [31:0] pack_hi(int s[7]);
      logic [31:0] d = '0;
      d[4:0] = 5'(s[5]);
      d[9:5] = 5'(s[6]);
      return d;
   endfunction

   function automatic int next_step(int st, int len);
      int eff = (len == 0) ? 1 : len;
      return (st + 1 >= eff) ? 0 : st + 1;
   endfunction

   // R2: the rising half must not move the step; the fall advances it
   task automatic pulse_vd(bit check_rise);
      @(negedge clk); vd = 1'b1;
      repeat (4) @(negedge clk);
      if (check_rise) chk("R2 rise ignored", int'(step_num), m_step);
      vd = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic fill(ref int s[7], input int seed);
      for (int k = 0; k < 7; k++) s[k] = (seed * 7 + k * 5 + 3) % 32;
   endtask

   initial begin
      for (int k = 0; k < 7; k++) m_slot[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 reset step", int'(step_num), 0);
      chk("R1 reset index", int'(field_idx), 0);
      pulse_vd(1'b0);
      chk("R1 reset length one", int'(step_num), 0);

      // R3 R4 R6: sweep all lengths, immediate mode
      for (int len = 0; len < 8; len++) begin
         fill(m_slot, len + 1);
         wr(0, 32'(len));
         wr(1, pack_lo(m_slot));
         wr(2, pack_hi(m_slot));
         m_len = len; m_step = 0;
         chk_out("R6 R4 programmed");
         for (int p = 0; p < 2 * 7 + 1; p++) begin
            pulse_vd(p == 0);
            m_step = next_step(m_step, m_len);
            chk_out("R3 R4 sweep");
         end
      end

      // R5: length and low-register writes keep the step; high write restarts
      fill(m_slot, 20);
      wr(0, 32'd7); wr(1, pack_lo(m_slot)); wr(2, pack_hi(m_slot));
      m_len = 7; m_step = 0;
      repeat (3) begin pulse_vd(1'b0); m_step = next_step(m_step, m_len); end
      fill(n_slot, 21);
      wr(0, 32'd7);
      chk("R5 len write keeps step", int'(step_num), 3);
      wr(1, pack_lo(n_slot));
      for (int k = 0; k < 5; k++) m_slot[k] = n_slot[k];
      chk_out("R5 R6 lo write keeps step");
      wr(0, 32'd6);
      m_len = 6;
      chk_out("R5 shorter len keeps step");
      wr(2, pack_hi(n_slot));
      m_slot[5] = n_slot[5]; m_slot[6] = n_slot[6];
      m_step = 0;
      chk_out("R5 hi write restarts");
      repeat (6) begin pulse_vd(1'b0); m_step = next_step(m_step, m_len); end
      chk_out("R3 wrap at length six");

      // R9: unmapped addresses
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      for (int a = 3; a < 16; a++) wr(a, 32'hFFFF_FFFF);
      chk_out("R9 unmapped write ignored");
      repeat (3) begin pulse_vd(1'b0); m_step = next_step(m_step, m_len); end
      chk_out("R9 sequence unchanged");

      // R7 R8: deferred mode
      @(negedge clk); upd_on_vd = 1'b1;
      fill(n_slot, 30);
      wr(0, 32'd2); wr(1, pack_lo(n_slot)); wr(2, pack_hi(n_slot));
      chk_out("R7 R8 write held");
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      chk_out("R7 first fall old settings");
      pulse_vd(1'b0);
      m_slot = n_slot; m_len = 2; m_step = 0;
      chk_out("R7 R8 second fall applies");
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      chk_out("R7 new length step two");
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      chk_out("R7 new length wraps");

      // R7: a later write restarts the two-edge count
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      fill(n_slot, 40);
      for (int k = 0; k < 5; k++) n_slot[k] = m_slot[k];
      wr(2, pack_hi(n_slot));
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      chk_out("R7 one fall not yet");
      wr(2, pack_hi(n_slot));
      pulse_vd(1'b0); m_step = next_step(m_step, m_len);
      chk_out("R7 rewrite restarts count");
      pulse_vd(1'b0);
      m_slot = n_slot; m_step = 0;
      chk_out("R8 applied with restart");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule